// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block maps a CPU's 16-bit address bus onto a cartridge whose ROM and RAM are much larger than the CPU can see at once. The lower half of the address space shows two 16 KB ROM windows. The first is pinned to bank 0. The second shows a bank chosen by software. An 8 KB window higher in the map shows one bank of external RAM.

Software controls the block by writing into the ROM address range. Those writes never reach the ROM. Instead, the top three address bits pick one of four control registers:

- a RAM unlock gate, opened only by a specific data nibble;
- a five-bit low ROM bank register, in which zero is replaced by one;
- a two-bit register whose meaning depends on the mode bit;
- the mode bit itself.

The block presents physical ROM and RAM addresses together with read and write enables. It also raises a flag that tells the data-bus mux to return 0xFF when the RAM window is read while RAM is locked.

Address outputs are combinational from the CPU address and the stored bank state. A control write takes effect at the clock edge that samples the strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write with address bits 15:13 = 000 (0x0000–0x1FFF) unlocks RAM when data bits 3:0 equal 0xA, and locks it for any other nibble, from the next clock edge.
- R2: A write with address bits 15:13 = 001 (0x2000–0x3FFF) loads data bits 4:0 into the low bank register; a value of 0 is stored as 1.
- R3: A write with address bits 15:13 = 010 (0x4000–0x5FFF) loads data bits 1:0 into the shared upper register.
- R4: A write with address bits 15:13 = 011 (0x6000–0x7FFF) loads the mode bit from data bit 0.
- R5: A read at 0x0000–0x3FFF asserts romRdEn and gives romAddr = address bits 13:0 (bank 0).
- R6: A read at 0x4000–0x7FFF gives romAddr = bank·0x4000 + address bits 13:0, truncated to ROM_AW bits. In mode 0 the bank is {upper, low}; in mode 1 it is {00, low}.
- R7: An access at 0xA000–0xBFFF gives ramAddr = ramBank·0x2000 + address bits 12:0, truncated to RAM_AW bits. ramBank is the upper register in mode 1 and 0 in mode 0.
- R8: While RAM is locked, ramRdEn and ramWrEn stay low, and a read of the RAM window raises ramFloat (the data bus is to read 0xFF).
- R9: romRdEn is asserted only for read strobes in 0x0000–0x7FFF, never for writes. ramRdEn and ramWrEn are asserted only in the RAM window. Other addresses assert no enable.
- R10: After reset the low bank is 1, the upper register is 0, the mode is 0 and RAM is locked.
- R11: Changing the mode re-interprets the stored upper register without a new write to it, moving it between ROM bank bits 6:5 and the RAM bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuRdEn | input | 1 | CPU read strobe |
| romAddr | output | ROM_AW (21) | Physical ROM byte address |
| romRdEn | output | 1 | ROM read enable |
| ramAddr | output | RAM_AW (15) | Physical RAM byte address |
| ramRdEn | output | 1 | RAM read enable |
| ramWrEn | output | 1 | RAM write enable |
| ramFloat | output | 1 | Read of locked RAM window; bus returns 0xFF |

## Verification
Enables and addresses are due in the same cycle as the CPU strobe. The bench therefore drives each access on the falling edge and samples the outputs 1 ns later, before the next rising edge. A control write changes the mapping from the rising edge that samples it onward. The bench's reference model applies the write after that edge, so the access in the following cycle is the first one checked against the new state. Directed sequences also pin exact addresses for the zero remap, both modes and unlock nibbles in both halves of the gate range.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Address bits 15:13 select a control register or the RAM window.
  localparam logic [2:0] SEL_GATE = 3'b000;
  localparam logic [2:0] SEL_LOW  = 3'b001;
  localparam logic [2:0] SEL_HIGH = 3'b010;
  localparam logic [2:0] SEL_MODE = 3'b011;
  localparam logic [2:0] SEL_XRAM = 3'b101;

  localparam int ROM_WIN_AW = 14;     // 16 KB ROM window
  localparam int RAM_WIN_AW = 13;     // 8 KB RAM window

  localparam logic [3:0] UNLOCK_KEY = 4'hA;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic ramGate;
    logic bankLow;
    logic bankHigh;
    logic modeBit;
  } regStrb_t;

endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  input  logic        ramOn,
  output regStrb_t    strb,
  output logic        romRdEn,
  output logic        ramRdEn,
  output logic        ramWrEn,
  output logic        ramFloat
);

  logic [2:0] sel;
  logic       inRom;
  logic       inRam;

  assign sel   = cpuAddr[15:13];
  assign inRom = (cpuAddr[15] == 1'b0);
  assign inRam = (sel == SEL_XRAM);

  // ROM-range writes are decoded as register loads.
  always_comb begin
    strb          = '0;
    strb.ramGate  = cpuWrEn && (sel == SEL_GATE);
    strb.bankLow  = cpuWrEn && (sel == SEL_LOW);
    strb.bankHigh = cpuWrEn && (sel == SEL_HIGH);
    strb.modeBit  = cpuWrEn && (sel == SEL_MODE);
  end

  assign romRdEn  = cpuRdEn && inRom;
  assign ramRdEn  = cpuRdEn && inRam && ramOn;
  assign ramWrEn  = cpuWrEn && inRam && ramOn;
  assign ramFloat = cpuRdEn && inRam && !ramOn;

endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int LOW_W  = 5,
  parameter int HI_W   = 2,
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramOn,
  output logic [LOW_W-1:0]  romLow,
  output logic [HI_W-1:0]   bankHi,
  output logic              modeSel
);

  localparam int BANK_W   = LOW_W + HI_W;
  localparam int ROM_FULL = BANK_W + ROM_WIN_AW;
  localparam int RAM_FULL = HI_W + RAM_WIN_AW;

  logic [LOW_W-1:0]    lowIn;
  logic [BANK_W-1:0]   swBank;
  logic [BANK_W-1:0]   romBank;
  logic [HI_W-1:0]     ramBank;
  logic [ROM_FULL-1:0] romFull;
  logic [RAM_FULL-1:0] ramFull;

  assign lowIn = cpuWrData[LOW_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramOn   <= 1'b0;
      romLow  <= LOW_W'(1);
      bankHi  <= '0;
      modeSel <= 1'b0;
    end else begin
      if (strb.ramGate)  ramOn   <= (cpuWrData[3:0] == UNLOCK_KEY);
      if (strb.bankLow)  romLow  <= (lowIn == '0) ? LOW_W'(1) : lowIn;
      if (strb.bankHigh) bankHi  <= cpuWrData[HI_W-1:0];
      if (strb.modeBit)  modeSel <= cpuWrData[0];
    end
  end

  // Mode routes the upper register either to ROM or to RAM.
  always_comb begin
    swBank  = modeSel ? {{HI_W{1'b0}}, romLow} : {bankHi, romLow};
    romBank = cpuAddr[ROM_WIN_AW] ? swBank : '0;
    ramBank = modeSel ? bankHi : '0;
    romFull = {romBank, cpuAddr[ROM_WIN_AW-1:0]};
    ramFull = {ramBank, cpuAddr[RAM_WIN_AW-1:0]};
  end

  generate
    if (ROM_AW >= ROM_FULL) begin : g_rom_ext
      assign romAddr = ROM_AW'(romFull);
    end else begin : g_rom_trunc
      assign romAddr = romFull[ROM_AW-1:0];
    end
    if (RAM_AW >= RAM_FULL) begin : g_ram_ext
      assign ramAddr = RAM_AW'(ramFull);
    end else begin : g_ram_trunc
      assign ramAddr = ramFull[RAM_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int LOW_W  = 5,
  parameter int HI_W   = 2,
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic              ramFloat
);

  regStrb_t         strb;
  logic             ramOn;
  logic [LOW_W-1:0] romLow;
  logic [HI_W-1:0]  bankHi;
  logic             modeSel;

  cbm_ctrl u_ctrl (
    .cpuAddr (cpuAddr),
    .cpuWrEn (cpuWrEn),
    .cpuRdEn (cpuRdEn),
    .ramOn   (ramOn),
    .strb    (strb),
    .romRdEn (romRdEn),
    .ramRdEn (ramRdEn),
    .ramWrEn (ramWrEn),
    .ramFloat(ramFloat)
  );

  cbm_datapath #(
    .LOW_W (LOW_W),
    .HI_W  (HI_W),
    .ROM_AW(ROM_AW),
    .RAM_AW(RAM_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .cpuWrData(cpuWrData),
    .romAddr  (romAddr),
    .ramAddr  (ramAddr),
    .ramOn    (ramOn),
    .romLow   (romLow),
    .bankHi   (bankHi),
    .modeSel  (modeSel)
  );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int LOW_W  = 5,
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cpuAddr,
  input logic [7:0]        cpuWrData,
  input logic              cpuWrEn,
  input logic              cpuRdEn,
  input logic [ROM_AW-1:0] romAddr,
  input logic              romRdEn,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              ramRdEn,
  input logic              ramWrEn,
  input logic              ramOn,
  input logic [LOW_W-1:0]  romLow,
  input logic              modeSel
);

  assert_ram_unlock_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr[15:13] == 3'b000 && cpuWrData[3:0] == 4'hA) |=> ramOn);

  assert_ram_lock_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr[15:13] == 3'b000 && cpuWrData[3:0] != 4'hA) |=> !ramOn);

  assert_low_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    romLow != '0);

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWrEn && cpuAddr[15:13] == 3'b011) |=> $stable(modeSel));

  assert_fixed_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && cpuAddr[15:14] == 2'b00) |-> (romRdEn && romAddr == ROM_AW'(cpuAddr[13:0])));

  assert_mode0_rambank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && (ramRdEn || ramWrEn)) |-> ((ramAddr >> 13) == '0));

  assert_locked_no_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ramOn |-> (!ramRdEn && !ramWrEn));

  assert_rom_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !cpuRdEn) |-> !romRdEn);

endmodule

bind cart_bank_mapper cbm_checker #(
  .LOW_W (LOW_W),
  .ROM_AW(ROM_AW),
  .RAM_AW(RAM_AW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuWrData(cpuWrData),
  .cpuWrEn  (cpuWrEn),
  .cpuRdEn  (cpuRdEn),
  .romAddr  (romAddr),
  .romRdEn  (romRdEn),
  .ramAddr  (ramAddr),
  .ramRdEn  (ramRdEn),
  .ramWrEn  (ramWrEn),
  .ramOn    (ramOn),
  .romLow   (romLow),
  .modeSel  (modeSel)
);

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;

  localparam int ROM_AW = 21;
  localparam int RAM_AW = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       cpuAddr = '0;
  logic [7:0]        cpuWrData = '0;
  logic              cpuWrEn = 1'b0;
  logic              cpuRdEn = 1'b0;
  logic [ROM_AW-1:0] romAddr;
  logic              romRdEn;
  logic [RAM_AW-1:0] ramAddr;
  logic              ramRdEn;
  logic              ramWrEn;
  logic              ramFloat;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state
  bit mRamOn;
  int mLow, mHi, mMode;
  longint sRom, sRam;
  bit sRomRd, sRamRd, sRamWr, sFloat;

  cart_bank_mapper #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .romAddr(romAddr), .romRdEn(romRdEn),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramFloat(ramFloat)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint modelRom(input int a);
    int bank;
    if (a < 'h4000) return longint'(a);
    bank = (mMode != 0) ? mLow : ((mHi << 5) | mLow);
    return ((longint'(bank) << 14) | longint'(a & 'h3FFF)) & ((64'd1 << ROM_AW) - 1);
  endfunction

  function automatic longint modelRam(input int a);
    int bank;
    bank = (mMode != 0) ? mHi : 0;
    return ((longint'(bank) << 13) | longint'(a & 'h1FFF)) & ((64'd1 << RAM_AW) - 1);
  endfunction

  // One bus cycle: drive on the falling edge, compare before the rising edge,
  // then apply any register write to the model after that edge.
  task automatic step(input int a, input int d, input bit wr, input bit rd);
    bit hit, eRomRd, eRamRd, eRamWr, eFloat;
    @(negedge clk);
    cpuAddr = 16'(a); cpuWrData = 8'(d); cpuWrEn = wr; cpuRdEn = rd;
    #1;
    sRom = longint'(romAddr); sRam = longint'(ramAddr);
    sRomRd = romRdEn; sRamRd = ramRdEn; sRamWr = ramWrEn; sFloat = ramFloat;
    hit    = (a >= 'hA000) && (a <= 'hBFFF);
    eRomRd = rd && (a < 'h8000);
    eRamRd = rd && hit && mRamOn;
    eRamWr = wr && hit && mRamOn;
    eFloat = rd && hit && !mRamOn;
    chk(sRomRd == eRomRd, "R9", "romRdEn", sRomRd, eRomRd);
    chk(sRamRd == eRamRd && sRamWr == eRamWr, "R8",
        "ramRdEn/ramWrEn", {sRamRd, sRamWr}, {eRamRd, eRamWr});
    chk(sFloat == eFloat, "R8", "ramFloat", sFloat, eFloat);
    if (eRomRd) chk(sRom == modelRom(a), (a < 'h4000) ? "R5" : "R6", "romAddr", sRom, modelRom(a));
    if (hit && mRamOn) chk(sRam == modelRam(a), "R7", "ramAddr", sRam, modelRam(a));
    @(posedge clk);
    if (wr) begin
      case (a >> 13)
        0: mRamOn = ((d & 'hF) == 'hA);
        1: mLow   = ((d & 'h1F) == 0) ? 1 : (d & 'h1F);
        2: mHi    = d & 'h3;
        3: mMode  = d & 1;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    mRamOn = 0; mLow = 1; mHi = 0; mMode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R10: reset state -- bank 1 in the switchable window, RAM locked
    step('h4000, 0, 0, 1);
    chk(sRom == 'h4000, "R10", "romAddr after reset", sRom, 'h4000);
    step('hA000, 0, 0, 1);
    chk(sFloat == 1 && sRamRd == 0, "R10", "RAM locked after reset", sFloat, 1);

    // R1: unlock with nibble A
    step('h0000, 'h0A, 1, 0);
    step('hA123, 0, 0, 1);
    chk(sRamRd == 1 && sRam == 'h0123, "R1", "ramAddr after unlock", sRam, 'h0123);

    // R2: zero written is stored as one
    step('h2000, 'h00, 1, 0);
    step('h5000, 0, 0, 1);
    chk(sRom == 'h5000, "R2", "zero remap", sRom, 'h5000);

    // R3 / R6: upper bits in mode 0
    step('h3000, 'h25, 1, 0);
    step('h4000, 'h03, 1, 0);
    step('h7FFF, 0, 0, 1);
    chk(sRom == 'h197FFF, "R3", "bank 0x65 top byte", sRom, 'h197FFF);

    // R5: fixed window ignores bank registers
    step('h3FFF, 0, 0, 1);
    chk(sRom == 'h3FFF, "R5", "fixed window", sRom, 'h3FFF);

    // R4 / R11: mode 1 moves upper bits to RAM
    step('h6000, 'h01, 1, 0);
    step('h4000, 0, 0, 1);
    chk(sRom == 'h14000, "R11", "mode 1 ROM bank", sRom, 'h14000);
    step('hBFFF, 0, 0, 1);
    chk(sRam == 'h7FFF, "R7", "mode 1 RAM bank 3", sRam, 'h7FFF);
    step('h7000, 'hFE, 1, 0);
    step('h4001, 0, 0, 1);
    chk(sRom == 'h194001, "R4", "mode bit 0 from 0xFE", sRom, 'h194001);

    // R8: lock and try to write
    step('h1000, 'h1B, 1, 0);
    step('hA000, 'h55, 1, 0);
    chk(sRamWr == 0, "R8", "write suppressed while locked", sRamWr, 0);
    step('hB000, 0, 0, 1);
    chk(sFloat == 1, "R8", "float read while locked", sFloat, 1);

    // R1: nibble A with upper bits set, top of gate range
    step('h1FFF, 'hFA, 1, 0);
    step('hA000, 'h55, 1, 0);
    chk(sRamWr == 1, "R1", "unlock via 0xFA", sRamWr, 1);

    // R2: low five bits zero although data non-zero
    step('h2000, 'h40, 1, 0);
    step('h4000, 0, 0, 1);
    chk(sRom == 'h184000, "R2", "0x40 remaps to bank 0x61", sRom, 'h184000);

    // R9: accesses outside the windows
    step('h8000, 'h12, 1, 0);
    chk(sRomRd == 0 && sRamWr == 0, "R9", "write at 0x8000", {sRomRd, sRamWr}, 0);
    step('hC000, 0, 0, 1);
    chk(sRomRd == 0 && sRamRd == 0, "R9", "read at 0xC000", {sRomRd, sRamRd}, 0);

    // Mixed traffic against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      int a, d, op;
      seed = seed * 1103515245 + 12345;
      a  = (seed >>> 8) & 'hFFFF;
      d  = (seed >>> 3) & 'hFF;
      op = (seed >>> 26) & 3;
      if (op == 3 && ((seed >>> 4) & 1)) a = 'hA000 | (a & 'h1FFF);
      if (op == 2 && ((seed >>> 5) & 3) == 0) d = 'h0A;
      step(a, d, op == 2, op != 2 && op != 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule